// File: doc/BRIEF.md
# Interrupt Status Polling Loop

This block implements the idle step (state code 010) of a top-level sequencer. When the sequencer enters that state, the block asks an external bus transfer engine to read the interrupt status register at address 0x76. It then inspects one status bit of each returned byte. When that bit is set, the block issues the same read again, and it keeps doing so until the bit reads clear. When the bit reads clear, the block emits a one-cycle finish pulse. The sequencer uses that pulse as the enable that moves its state register on to 011.

The read request is always the same. The direction is read, the address is 0x76, and the write data is zero. Only the go strobe changes. At most one read is in flight at any time. Completions and data that arrive outside state 010, or while no read is outstanding, have no effect. The other bits of the status byte are not decoded here.

The controller has five named states:
- OFF: the sequencer is elsewhere.
- ISSUE: the go strobe is high.
- WAIT: a read is in flight.
- FIN: the finish pulse is high.
- HOLD: the read has finished and the sequencer is still at 010.

Its transitions are:
- OFF→ISSUE: state-enable seen.
- ISSUE→WAIT: always, while enabled.
- WAIT→ISSUE: completion with the status bit set.
- WAIT→FIN: completion with the bit clear.
- FIN→HOLD: still enabled.
- Any state→OFF: state-enable low.

Top module: `intr_poll_loop`

## Requirements
- R1: The asynchronous active-low reset `rst_n` forces `xfer_go` and `poll_done` low, both during reset and in the first cycle after it ends.
- R2: After the first clock edge at which `seq_state` equals 3'b010, where it was not 3'b010 at the previous edge, `xfer_go` is high for exactly one cycle, the cycle that follows that edge.
- R3: `xfer_rd` is always 1 (1 = read), `xfer_addr` is always 8'h76, and `xfer_wdata` is always 8'h00.
- R4: A read is outstanding from the cycle after `xfer_go` until its completion. If `xfer_done` arrives while the state is 3'b010, a read is outstanding and bit 6 of `xfer_rdata` is 1, then `xfer_go` is high in the next cycle only. The other data bits make no difference.
- R5: If `xfer_done` arrives while the state is 3'b010, a read is outstanding and bit 6 of `xfer_rdata` is 0, then `poll_done` is high for the next cycle only and no go is issued. The other data bits make no difference.
- R6: `xfer_done` has no effect while `seq_state` is not 3'b010. One cycle after any edge at which the state is not 3'b010, both outputs are low.
- R7: After `poll_done`, no new go is issued while the state stays at 3'b010. A completion arriving in that period is ignored. A new poll starts only after the state leaves 3'b010 and enters it again.
- R8: If the state leaves 3'b010 while a read is outstanding, that read is abandoned. Its later completion has no effect, even after the state returns to 3'b010.
- R9: At most one read is outstanding. `xfer_go` is never high while a read is outstanding. A `xfer_done` that coincides with the go cycle is ignored. `xfer_go` and `poll_done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_state | input | 3 | Current sequencer state; this block is active at 3'b010 |
| xfer_done | input | 1 | One-cycle completion strobe from the transfer engine |
| xfer_rdata | input | 8 | Byte returned by the completed read |
| xfer_go | output | 1 | One-cycle start strobe to the transfer engine |
| xfer_rd | output | 1 | Transfer direction, constant 1 (read) |
| xfer_addr | output | 8 | Transfer address, constant 8'h76 |
| xfer_wdata | output | 8 | Transfer write data, constant 8'h00 |
| poll_done | output | 1 | One-cycle pulse that advances the sequencer to 011 |

## Verification
The hardest case to reach from the ports is a completion that arrives when no read is outstanding while the state still reads 010. This covers three windows: the go cycle itself, the period after the finish pulse, and a return to 010 after a read was abandoned. The bench reaches each window by timing `xfer_done` against its own count of edges since the state was driven to 010. It drives `xfer_done` exactly in the go cycle, a few cycles into the hold period, and after a leave-and-return sequence. It also sends bytes whose other bits are all set while bit 6 is clear, and the reverse, to show that only bit 6 decides the outcome.

// File: rtl/intr_poll_pkg.sv
package intr_poll_pkg;

    typedef enum logic [2:0] {
        PL_OFF   = 3'd0,
        PL_ISSUE = 3'd1,
        PL_WAIT  = 3'd2,
        PL_FIN   = 3'd3,
        PL_HOLD  = 3'd4
    } poll_st_e;

    function automatic logic [7:0] bit_mask8(input int unsigned idx);
        logic [7:0] m;
        m = '0;
        m[idx[2:0]] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ipl_seq_fsm.sv
module ipl_seq_fsm
    import intr_poll_pkg::*;
#(
    parameter int unsigned SEQ_W    = 3,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned STAT_BIT = 6,
    parameter logic [SEQ_W-1:0] ACTIVE_CODE = 3'b010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEQ_W-1:0]  seq_state,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] xfer_rdata,
    output logic              issue,
    output logic              finish
);

    localparam logic [DATA_W-1:0] STAT_MASK = DATA_W'(1) << STAT_BIT;

    poll_st_e cur_st;
    poll_st_e nxt_st;
    logic     enabled;
    logic     status_set;

    assign enabled    = (seq_state == ACTIVE_CODE);
    assign status_set = ((xfer_rdata & STAT_MASK) != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_st <= PL_OFF;
        end else begin
            cur_st <= nxt_st;
        end
    end

    // transition logic
    always_comb begin
        nxt_st = cur_st;
        if (!enabled) begin
            nxt_st = PL_OFF;
        end else begin
            unique case (cur_st)
                PL_OFF:   nxt_st = PL_ISSUE;
                PL_ISSUE: nxt_st = PL_WAIT;
                PL_WAIT: begin
                    if (xfer_done) begin
                        nxt_st = status_set ? PL_ISSUE : PL_FIN;
                    end
                end
                PL_FIN:   nxt_st = PL_HOLD;
                PL_HOLD:  nxt_st = PL_HOLD;
                default:  nxt_st = PL_OFF;
            endcase
        end
    end

    // output decode
    always_comb begin
        issue  = 1'b0;
        finish = 1'b0;
        unique case (cur_st)
            PL_ISSUE: issue  = 1'b1;
            PL_FIN:   finish = 1'b1;
            default: begin
                issue  = 1'b0;
                finish = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ipl_fetch_port.sv
module ipl_fetch_port #(
    parameter int unsigned DATA_W = 8,
    parameter logic [DATA_W-1:0] STAT_ADDR = 8'h76,
    parameter bit READ_LEVEL = 1'b1
) (
    input  logic              issue,
    output logic              xfer_go,
    output logic              xfer_rd,
    output logic [DATA_W-1:0] xfer_addr,
    output logic [DATA_W-1:0] xfer_wdata
);

    generate
        if (READ_LEVEL) begin : g_rd_high
            assign xfer_rd = 1'b1;
        end else begin : g_rd_low
            assign xfer_rd = 1'b0;
        end
    endgenerate

    assign xfer_go    = issue;
    assign xfer_addr  = STAT_ADDR;
    assign xfer_wdata = '0;

endmodule

// File: rtl/intr_poll_loop.sv
module intr_poll_loop #(
    parameter int unsigned SEQ_W    = 3,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned STAT_BIT = 6,
    parameter logic [SEQ_W-1:0]  ACTIVE_CODE = 3'b010,
    parameter logic [DATA_W-1:0] STAT_ADDR   = 8'h76
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEQ_W-1:0]  seq_state,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] xfer_rdata,
    output logic              xfer_go,
    output logic              xfer_rd,
    output logic [DATA_W-1:0] xfer_addr,
    output logic [DATA_W-1:0] xfer_wdata,
    output logic              poll_done
);

    logic issue_w;
    logic finish_w;

    ipl_seq_fsm #(
        .SEQ_W       (SEQ_W),
        .DATA_W      (DATA_W),
        .STAT_BIT    (STAT_BIT),
        .ACTIVE_CODE (ACTIVE_CODE)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_state  (seq_state),
        .xfer_done  (xfer_done),
        .xfer_rdata (xfer_rdata),
        .issue      (issue_w),
        .finish     (finish_w)
    );

    ipl_fetch_port #(
        .DATA_W     (DATA_W),
        .STAT_ADDR  (STAT_ADDR),
        .READ_LEVEL (1'b1)
    ) u_port (
        .issue      (issue_w),
        .xfer_go    (xfer_go),
        .xfer_rd    (xfer_rd),
        .xfer_addr  (xfer_addr),
        .xfer_wdata (xfer_wdata)
    );

    assign poll_done = finish_w;

endmodule

// File: rtl/intr_poll_loop_chk.sv
module intr_poll_loop_chk #(
    parameter int unsigned SEQ_W    = 3,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned STAT_BIT = 6,
    parameter logic [SEQ_W-1:0]  ACTIVE_CODE = 3'b010,
    parameter logic [DATA_W-1:0] STAT_ADDR   = 8'h76
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEQ_W-1:0]  seq_state,
    input logic              xfer_done,
    input logic [DATA_W-1:0] xfer_rdata,
    input logic              xfer_go,
    input logic              xfer_rd,
    input logic [DATA_W-1:0] xfer_addr,
    input logic [DATA_W-1:0] xfer_wdata,
    input logic              poll_done
);

    localparam logic [DATA_W-1:0] MASK = DATA_W'(1) << STAT_BIT;

    logic en;
    logic bit_hi;
    logic out_q;
    logic fin_q;

    assign en     = (seq_state == ACTIVE_CODE);
    assign bit_hi = ((xfer_rdata & MASK) != '0);

    // independent tracking of the outstanding read and the post-finish period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            if (!en)            out_q <= 1'b0;
            else if (xfer_go)   out_q <= 1'b1;
            else if (xfer_done) out_q <= 1'b0;
            if (!en)            fin_q <= 1'b0;
            else if (poll_done) fin_q <= 1'b1;
        end
    end

    assert_fixed_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_rd && (xfer_addr == STAT_ADDR) && (xfer_wdata == '0));

    assert_entry_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> xfer_go);

    assert_go_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |=> !xfer_go);

    assert_loop_refetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && out_q && xfer_done && bit_hi) |=> xfer_go);

    assert_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && out_q && xfer_done && !bit_hi) |=> (poll_done && !xfer_go));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        poll_done |=> !poll_done);

    assert_quiet_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!xfer_go && !poll_done));

    assert_no_refetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |-> !xfer_go);

    assert_one_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |-> !xfer_go);

    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_go && poll_done));

endmodule

bind intr_poll_loop intr_poll_loop_chk #(
    .SEQ_W       (SEQ_W),
    .DATA_W      (DATA_W),
    .STAT_BIT    (STAT_BIT),
    .ACTIVE_CODE (ACTIVE_CODE),
    .STAT_ADDR   (STAT_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_state  (seq_state),
    .xfer_done  (xfer_done),
    .xfer_rdata (xfer_rdata),
    .xfer_go    (xfer_go),
    .xfer_rd    (xfer_rd),
    .xfer_addr  (xfer_addr),
    .xfer_wdata (xfer_wdata),
    .poll_done  (poll_done)
);

// File: tb/intr_poll_loop_test.sv
`timescale 1ns/1ps
module intr_poll_loop_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] seq_state = 3'b000;
    logic       xfer_done = 1'b0;
    logic [7:0] xfer_rdata = 8'h00;
    logic       xfer_go;
    logic       xfer_rd;
    logic [7:0] xfer_addr;
    logic [7:0] xfer_wdata;
    logic       poll_done;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // reference model variables
    bit m_entered = 0;
    bit m_pending = 0;
    bit m_go = 0;
    bit m_done = 0;

    always #4 clk = ~clk;   // 125 MHz

    intr_poll_loop uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_state  (seq_state),
        .xfer_done  (xfer_done),
        .xfer_rdata (xfer_rdata),
        .xfer_go    (xfer_go),
        .xfer_rd    (xfer_rd),
        .xfer_addr  (xfer_addr),
        .xfer_wdata (xfer_wdata),
        .poll_done  (poll_done)
    );

    // behavioural reference, evaluated at each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_entered = 0; m_pending = 0; m_go = 0; m_done = 0;
        end else begin
            bit was_go;
            bit nx_go;
            bit nx_done;
            was_go  = m_go;
            nx_go   = 0;
            nx_done = 0;
            if (seq_state != 3'b010) begin
                m_entered = 0;
                m_pending = 0;
            end else if (!m_entered) begin
                m_entered = 1;
                m_pending = 1;
                nx_go = 1;
            end else if (m_pending && !was_go && xfer_done) begin
                if (xfer_rdata[6]) nx_go = 1;
                else begin
                    nx_done = 1;
                    m_pending = 0;
                end
            end
            m_go = nx_go;
            m_done = nx_done;
        end
    end

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        cyc++;
        check(cur_req, "xfer_go", {7'd0, xfer_go}, {7'd0, m_go});
        check(cur_req, "poll_done", {7'd0, poll_done}, {7'd0, m_done});
        check("R3", "xfer_rd", {7'd0, xfer_rd}, 8'h01);
        check("R3", "xfer_addr", xfer_addr, 8'h76);
        check("R3", "xfer_wdata", xfer_wdata, 8'h00);
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_done(input logic [7:0] d);
        xfer_done = 1'b1;
        xfer_rdata = d;
        @(negedge clk);
        xfer_done = 1'b0;
        xfer_rdata = 8'h00;
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            report();
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R2, R5: simple entry then clear status bit
        cur_req = "R2";
        seq_state = 3'b010;
        tick(3);
        cur_req = "R5";
        pulse_done(8'hBF);      // bit 6 clear, others set
        tick(2);

        // R7: stay in 010, stray completion ignored, no new go
        cur_req = "R7";
        tick(2);
        pulse_done(8'h00);
        pulse_done(8'h40);
        tick(3);

        // R6: leave state, completions ignored
        cur_req = "R6";
        seq_state = 3'b011;
        tick(2);
        pulse_done(8'h40);
        pulse_done(8'h00);
        seq_state = 3'b000;
        tick(2);

        // R4: loop several times, then finish
        cur_req = "R4";
        seq_state = 3'b010;
        tick(2);
        pulse_done(8'h40);
        tick(1);
        pulse_done(8'hFF);
        tick(4);
        pulse_done(8'h7F);
        tick(1);
        cur_req = "R5";
        pulse_done(8'h80);
        tick(2);
        seq_state = 3'b011;
        tick(2);

        // R9: completion exactly in the go cycle is ignored
        cur_req = "R9";
        seq_state = 3'b010;
        @(negedge clk);          // edge sampled 010; go high now
        pulse_done(8'h00);       // coincides with go cycle
        tick(2);
        pulse_done(8'h40);       // genuine completion -> loop
        pulse_done(8'h00);       // coincides with refetch go
        tick(1);
        pulse_done(8'h00);       // genuine completion -> finish
        tick(2);
        seq_state = 3'b000;
        tick(2);

        // R8: leave while outstanding, stale completion ignored
        cur_req = "R8";
        seq_state = 3'b010;
        tick(3);
        seq_state = 3'b001;
        tick(1);
        pulse_done(8'h00);
        tick(1);
        seq_state = 3'b010;
        @(negedge clk);          // re-entry go
        tick(2);
        pulse_done(8'h00);
        tick(3);
        seq_state = 3'b000;
        tick(2);

        // R1: asynchronous reset in the middle of a wait
        cur_req = "R1";
        seq_state = 3'b010;
        tick(3);
        #2 rst_n = 1'b0;
        tick(2);
        seq_state = 3'b000;
        rst_n = 1'b1;
        tick(3);

        report();
    end

endmodule